// File: doc/BRIEF.md
# Host Bus Front End for a Graphic Display Controller

This block receives bytes from a host processor and hands them to the display controller. It works in one of three host modes. Two of them are 8-bit parallel buses: one with a single enable and a read/write level, and one with separate active-low read and write strobes. The third is a write-only serial link with a clock and a data line. Two static strap inputs pick the mode. The device responds only while its active-low select is low and its active-high select is high.

All host pins pass through a two-stage synchronizer into the system clock domain. Strobe edges are detected on the synchronized copies. Each accepted byte produces a one-cycle pulse that carries the byte and its data/command flag.

For parallel reads the block drives an output byte and an output-enable for an external tri-state pad. With the flag low, the output byte is a status byte whose bit 7 is the busy flag. With the flag high, it is read data supplied by the display side. While busy is high, only status reads are served and writes are dropped.

Top module: `host_bus_if`

## Requirements
- R1: No byte is accepted and the bus is not driven unless `cs_a_n` is low and `cs_b` is high at the same time.
- R2: With `bus_sel_68`=0 and `par_mode`=1, a write is taken when `wr_rw` rises. The byte comes from `din` and the flag from `a0` as they stood just before that rising edge.
- R3: With `bus_sel_68`=1 and `par_mode`=1, a write is taken when `rd_en` falls while `wr_rw` is low. The byte and flag are those present while `rd_en` was high.
- R4: A status read (`a0`=0) drives `dout` = {busy, `status_flags`[6:0]} with `dout_oe`=1. In strobe timing this happens while `rd_en` is low; in enable timing it happens while `rd_en`=1 and `wr_rw`=1.
- R5: A data read (`a0`=1) drives `dout` = `rd_data` with `dout_oe`=1, under the same strobe conditions as R4.
- R6: While `busy` is 1, writes in every mode produce no pulse and data reads leave `dout_oe`=0. Status reads are still served.
- R7: With `par_mode`=0, `sdi` is sampled on each rising `sclk`, most significant bit first. The 8th rising edge delivers the byte, with the flag taken from `a0` at that edge.
- R8: Deselecting the chip in serial mode clears the bit count, so a partial byte is discarded. The next full byte is received intact.
- R9: With `par_mode`=0, no read is served: `dout_oe` stays 0 whatever the strobes do.
- R10: Reset clears the serial shift state and bit count and holds `byte_valid`=0 and `dout_oe`=0.
- R11: Each accepted byte produces exactly one `byte_valid` pulse, one clock cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| par_mode | input | 1 | Strap: 1 parallel, 0 serial |
| bus_sel_68 | input | 1 | Strap: 1 enable timing, 0 strobe timing |
| cs_a_n | input | 1 | Active-low chip select |
| cs_b | input | 1 | Active-high chip select |
| a0 | input | 1 | 1 display data, 0 command/status |
| rd_en | input | 1 | Read strobe (active low) or enable (active high) |
| wr_rw | input | 1 | Write strobe (active low) or read/write level |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data |
| din | input | 8 | Parallel data from the pad |
| dout | output | 8 | Parallel data to the pad |
| dout_oe | output | 1 | Pad output enable |
| busy | input | 1 | Controller busy flag |
| status_flags | input | 7 | Lower status bits |
| rd_data | input | 8 | Display read data |
| byte_valid | output | 1 | One-cycle byte pulse |
| byte_out | output | 8 | Received byte |
| byte_is_data | output | 1 | Flag of received byte |

## Verification
The assertions assume that host pins change slowly compared with the system clock. Every high and low phase of a strobe or serial clock must span at least two sampling cycles, so no edge is lost in the synchronizer. They also assume the straps change only while the chip is deselected. The bench holds every pin level for four clock cycles before the next change and moves the straps only with a select inactive. Under these conditions two accepted bytes can never land on adjacent cycles, and the serial count returns to zero one cycle after deselection.

// File: rtl/host_bus_if.sv
module host_bus_if #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         par_mode,
  input  logic         bus_sel_68,
  input  logic         cs_a_n,
  input  logic         cs_b,
  input  logic         a0,
  input  logic         rd_en,
  input  logic         wr_rw,
  input  logic         sclk,
  input  logic         sdi,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_oe,
  input  logic         busy,
  input  logic [W-2:0] status_flags,
  input  logic [W-1:0] rd_data,
  output logic         byte_valid,
  output logic [W-1:0] byte_out,
  output logic         byte_is_data
);
  localparam int SDI = W;
  localparam int SCK = W + 1;
  localparam int WRP = W + 2;
  localparam int RDP = W + 3;
  localparam int A0P = W + 4;
  localparam int CSB = W + 5;
  localparam int CSA = W + 6;
  localparam int PAR = W + 7;
  localparam int M68 = W + 8;
  localparam int VW  = W + 9;
  localparam int CW  = $clog2(W);

  logic [VW-1:0] s1, cur, prv;
  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;

  wire [VW-1:0] pins = {bus_sel_68, par_mode, cs_a_n, cs_b, a0, rd_en, wr_rw, sclk, sdi, din};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1; cur <= '1; prv <= '1;
    end else begin
      s1 <= pins; cur <= s1; prv <= cur;
    end

  wire sel_c = !cur[CSA] && cur[CSB];
  wire sel_p = !prv[CSA] && prv[CSB];
  wire wr80  = !prv[M68] && !prv[WRP] && cur[WRP];
  wire wr68  = prv[M68] && prv[RDP] && !cur[RDP] && !prv[WRP];
  wire pwr   = sel_p && prv[PAR] && (wr80 || wr68);
  wire ser_on = sel_c && !cur[PAR];
  wire srise = ser_on && !prv[SCK] && cur[SCK];
  wire sdone = srise && (cnt == CW'(W - 1));
  wire rd_act = sel_c && cur[PAR] &&
                (cur[M68] ? (cur[RDP] && cur[WRP]) : !cur[RDP]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      shreg <= '0;
    end else if (!ser_on) begin
      cnt <= '0;
    end else if (srise) begin
      cnt <= cnt + 1'b1;
      shreg <= {shreg[W-2:0], cur[SDI]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      byte_valid <= 1'b0;
      byte_out <= '0;
      byte_is_data <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (pwr && !busy) begin
        byte_valid <= 1'b1;
        byte_out <= prv[W-1:0];
        byte_is_data <= prv[A0P];
      end else if (sdone && !busy) begin
        byte_valid <= 1'b1;
        byte_out <= {shreg[W-2:0], cur[SDI]};
        byte_is_data <= cur[A0P];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dout_oe <= 1'b0;
      dout <= '0;
    end else begin
      dout_oe <= rd_act && (!cur[A0P] || !busy);
      dout <= cur[A0P] ? rd_data : {busy, status_flags};
    end

  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !$past(busy));
  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_c |=> cnt == '0);
  // R9
  serial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur[PAR] && !prv[PAR]) |=> !dout_oe);
  // R1
  sel_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(sel_c));
endmodule

// File: tb/sim_host_bus_if.sv
module sim_host_bus_if;
  logic clk = 0, rst_n = 0;
  logic par_mode = 1, bus_sel_68 = 0, cs_a_n = 1, cs_b = 0, a0 = 0;
  logic rd_en = 1, wr_rw = 1, sclk = 0, sdi = 0, busy = 0;
  logic [7:0] din = 0, rd_data = 0, dout, byte_out;
  logic [6:0] status_flags = 0;
  logic dout_oe, byte_valid, byte_is_data;
  int checks = 0, fails = 0, npulse = 0;
  logic [7:0] last_b;
  logic last_a;

  always #4 clk = ~clk;

  host_bus_if u0 (.*);

  always @(posedge clk) if (byte_valid) begin
    npulse++; last_b = byte_out; last_a = byte_is_data;
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic hold(); repeat (4) @(negedge clk); endtask

  task automatic sel(logic on); cs_a_n = !on; cs_b = on; hold(); endtask

  task automatic w80(logic f, logic [7:0] d);
    a0 = f; din = d; hold(); wr_rw = 0; hold(); wr_rw = 1; hold(); hold();
  endtask

  task automatic w68(logic f, logic [7:0] d);
    a0 = f; din = d; wr_rw = 0; hold(); rd_en = 1; hold(); rd_en = 0; hold();
    wr_rw = 1; hold();
  endtask

  task automatic rd80(string r, logic f, logic oe, logic [7:0] d);
    a0 = f; hold(); rd_en = 0; repeat (6) @(negedge clk);
    chk(r, dout_oe, oe);
    if (oe) chk(r, dout, d);
    rd_en = 1; hold();
  endtask

  task automatic sbyte(logic f, logic [7:0] d, int n);
    a0 = f;
    for (int i = 7; i > 7 - n; i--) begin
      sdi = d[i]; hold(); sclk = 1; hold(); sclk = 0;
    end
    hold(); hold();
  endtask

  task automatic t_reset();
    chk("R10 oe", dout_oe, 0); chk("R10 valid", byte_valid, 0);
    chk("R10 pulses", npulse, 0);
  endtask

  task automatic t_w80();
    int n0;
    sel(1); n0 = npulse;
    w80(0, 8'hA5);
    chk("R2 cnt", npulse, n0 + 1); chk("R2 byte", last_b, 8'hA5); chk("R2 a0", last_a, 0);
    w80(1, 8'h3C);
    chk("R11 cnt", npulse, n0 + 2); chk("R2 byte2", last_b, 8'h3C); chk("R2 a0b", last_a, 1);
    sel(0);
  endtask

  task automatic t_desel();
    int n0 = npulse;
    cs_a_n = 0; cs_b = 0; hold(); w80(0, 8'h11);
    cs_a_n = 1; cs_b = 1; hold(); w80(0, 8'h22);
    chk("R1 no write", npulse, n0);
    rd80("R1 no drive", 0, 0, 0);
    sel(0);
  endtask

  task automatic t_status();
    sel(1); status_flags = 7'h15; busy = 0;
    rd80("R4 idle", 0, 1, 8'h15);
    busy = 1;
    rd80("R4 R6 busy status", 0, 1, 8'h95);
    busy = 0; sel(0);
  endtask

  task automatic t_68();
    int n0;
    bus_sel_68 = 1; rd_en = 0; wr_rw = 1; hold();
    sel(1); n0 = npulse;
    w68(1, 8'h5A);
    chk("R3 cnt", npulse, n0 + 1); chk("R3 byte", last_b, 8'h5A); chk("R3 a0", last_a, 1);
    rd_data = 8'hC3; a0 = 1; wr_rw = 1; hold(); rd_en = 1; repeat (6) @(negedge clk);
    chk("R5 oe", dout_oe, 1); chk("R5 data", dout, 8'hC3);
    rd_en = 0; hold();
    chk("R5 release", dout_oe, 0);
    sel(0); bus_sel_68 = 0; rd_en = 1; wr_rw = 1; hold();
  endtask

  task automatic t_busy();
    int n0;
    sel(1); busy = 1; n0 = npulse;
    w80(0, 8'h77);
    chk("R6 write dropped", npulse, n0);
    rd_data = 8'h5E;
    rd80("R6 data read", 1, 0, 0);
    busy = 0;
    rd80("R5 data read 80", 1, 1, 8'h5E);
    sel(0);
  endtask

  task automatic t_serial();
    int n0;
    par_mode = 0; hold(); sel(1); n0 = npulse;
    sbyte(1, 8'h96, 8);
    chk("R7 cnt", npulse, n0 + 1); chk("R7 byte", last_b, 8'h96); chk("R7 a0", last_a, 1);
    sbyte(0, 8'hFF, 5);
    chk("R8 partial", npulse, n0 + 1);
    sel(0); sel(1);
    sbyte(0, 8'h0F, 8);
    chk("R8 byte", last_b, 8'h0F); chk("R8 cnt", npulse, n0 + 2);
    rd80("R9 serial read", 0, 0, 0);
    sbyte(0, 8'hAA, 3);
    rst_n = 0; hold(); chk("R10 oe mid", dout_oe, 0); rst_n = 1; hold();
    sbyte(1, 8'h4B, 8);
    chk("R10 after reset", last_b, 8'h4B); chk("R11 serial cnt", npulse, n0 + 3);
    sel(0); par_mode = 1; hold();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rst_n = 1; hold();
        t_reset(); t_w80(); t_desel(); t_status(); t_68(); t_busy(); t_serial();
      end
      begin
        repeat (100000) @(negedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule